// File: doc/BRIEF.md
# Saturating Signed Add/Subtract Unit with Sticky Saturation Flag

This block performs 32-bit signed arithmetic that clamps instead of wrapping. Four operations share one adder: add, subtract, reverse subtract, and subtract of a sign-extended immediate. When the true result does not fit in the signed range, the output is pinned to the most positive or most negative value. A five-bit status register is updated from the operation: zero, sign, overflow, carry and a saturation flag.

The saturation flag is sticky. Once any operation has clamped, the flag stays set through later operations that do not overflow. Only a write through the status write port brings it back to zero. The carry flag describes the raw, unclamped carry or borrow. The sign and zero flags describe the value that is actually delivered.

A pipeline stage ahead of this block supplies the two register operands, the immediate and an operation code with a valid strobe. It takes the registered result one cycle later. The status write port gives the surrounding control logic direct load access to the flags.

Top module: `sat_alu_unit`

## Requirements
- R1: When an operation overflows in the positive direction, the result is 0x7FFFFFFF. When it overflows in the negative direction, the result is 0x80000000.
- R2: An operation that clamps sets OV to 1 and SAT to 1.
- R3: No operation ever clears SAT. After a clamp, a later operation that does not overflow leaves SAT at 1. An operation started with SAT at 0 that does not overflow leaves SAT at 0.
- R4: CY is the carry out of the unclamped addition. For subtraction, CY is the borrow, which is 1 when the minuend is below the subtrahend as unsigned numbers. This holds whether or not the result is clamped.
- R5: S equals bit 31 of the delivered (clamped) result. Z is 1 exactly when the delivered result is zero.
- R6: A result that lands exactly on 0x7FFFFFFF or 0x80000000 without overflowing leaves OV at 0 and does not set SAT.
- R7: The operation code selects one of four operations:
  - 0 gives dst + src.
  - 1 gives dst − src.
  - 2 gives src − dst.
  - 3 gives dst − sext(imm), where the 16-bit immediate is sign-extended to 32 bits.
- R8: The status register layout is Z at bit 0, S at bit 1, OV at bit 2, CY at bit 3 and SAT at bit 4. A write strobe loads all five bits from the write data on the next edge. When a write and an operation fall in the same cycle, the written value wins for the flags, and the result is still updated.
- R9: The result and the flags change only on the clock edge where the operation valid strobe (or, for the flags, the write strobe) is high. The new values are visible right after that edge. With neither strobe high, both hold their values.
- R10: Reset clears the result and all five flags to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Start an operation this cycle |
| op_sel | input | 2 | Operation code (see R7) |
| src_opnd | input | 32 | Source register operand |
| dst_opnd | input | 32 | Destination register operand |
| imm_opnd | input | 16 | Immediate, sign-extended for operation 3 |
| stat_wr | input | 1 | Status register write strobe |
| stat_wr_data | input | 5 | Value loaded into the status register |
| result | output | 32 | Registered clamped result |
| status | output | 5 | Status flags {SAT, CY, OV, S, Z} |

## Verification
The assertions assume that `op_valid` and `stat_wr` are never unknown after reset. The clamp and flag checks are gated on `op_valid` with `stat_wr` low, so those properties never have to decide which source owns the flags. The bench drives every input at the falling edge and keeps both strobes high for exactly one cycle. In each vector it loads a known status with a write cycle before the operation, so that the sticky SAT state entering the operation is always defined.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_RSUB = 2'd2,
    OP_SUBI = 2'd3
  } sat_op_e;

  localparam int FLAG_W = 5;
  localparam int FLG_Z   = 0;
  localparam int FLG_S   = 1;
  localparam int FLG_OV  = 2;
  localparam int FLG_CY  = 3;
  localparam int FLG_SAT = 4;

endpackage

// File: rtl/sat_arith_core.sv
module sat_arith_core
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  sat_op_e             op,
  input  logic [DATA_W-1:0]   src,
  input  logic [DATA_W-1:0]   dst,
  input  logic [IMM_W-1:0]    imm,
  output logic [DATA_W-1:0]   clamped,
  output logic                ovf,
  output logic                carry
);

  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] POS_LIMIT = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIMIT = {1'b1, {(DATA_W-1){1'b0}}};

  // Signed overflow: compare operand signs against the wrapped result sign.
  function automatic logic detect_ovf(input logic is_sub, input logic xs,
                                      input logic ys, input logic rs);
    if (is_sub) return (xs != ys) && (rs != xs);
    else        return (xs == ys) && (rs != xs);
  endfunction

  // Clamp direction follows the sign of the left operand.
  function automatic logic [DATA_W-1:0] clamp_val(input logic ov_hit, input logic xs,
                                                  input logic [DATA_W-1:0] raw);
    if (!ov_hit) return raw;
    return xs ? NEG_LIMIT : POS_LIMIT;
  endfunction

  logic [DATA_W-1:0] lhs, rhs, imm_ext;
  logic              is_sub;
  logic [DATA_W:0]   wide;
  logic [DATA_W-1:0] raw_val;

  assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    lhs    = dst;
    rhs    = src;
    is_sub = 1'b0;
    unique case (op)
      OP_ADD:  begin lhs = dst; rhs = src;     is_sub = 1'b0; end
      OP_SUB:  begin lhs = dst; rhs = src;     is_sub = 1'b1; end
      OP_RSUB: begin lhs = src; rhs = dst;     is_sub = 1'b1; end
      OP_SUBI: begin lhs = dst; rhs = imm_ext; is_sub = 1'b1; end
      default: begin lhs = dst; rhs = src;     is_sub = 1'b0; end
    endcase
  end

  assign wide    = is_sub ? ({1'b0, lhs} - {1'b0, rhs}) : ({1'b0, lhs} + {1'b0, rhs});
  assign raw_val = wide[DATA_W-1:0];
  assign carry   = wide[DATA_W];
  assign ovf     = detect_ovf(is_sub, lhs[MSB], rhs[MSB], raw_val[MSB]);
  assign clamped = clamp_val(ovf, lhs[MSB], raw_val);

endmodule

// File: rtl/sat_flag_reg.sv
module sat_flag_reg
  import sat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              new_z,
  input  logic              new_s,
  input  logic              new_ov,
  input  logic              new_cy,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [FLAG_W-1:0] flags_q
);

  logic [FLAG_W-1:0] op_flags;

  always_comb begin
    op_flags          = '0;
    op_flags[FLG_Z]   = new_z;
    op_flags[FLG_S]   = new_s;
    op_flags[FLG_OV]  = new_ov;
    op_flags[FLG_CY]  = new_cy;
    op_flags[FLG_SAT] = flags_q[FLG_SAT] | new_ov;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (wr_en)  flags_q <= wr_data;
    else if (upd_en) flags_q <= op_flags;
  end

  // R3: an operation never clears a set SAT flag
  a_r3_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[FLG_SAT] && !wr_en) |=> flags_q[FLG_SAT]);

  // R8: a write strobe loads the status exactly
  a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (flags_q == $past(wr_data)));

endmodule

// File: rtl/sat_alu_unit.sv
module sat_alu_unit
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] src_opnd,
  input  logic [DATA_W-1:0] dst_opnd,
  input  logic [IMM_W-1:0]  imm_opnd,
  input  logic              stat_wr,
  input  logic [4:0]        stat_wr_data,
  output logic [DATA_W-1:0] result,
  output logic [4:0]        status
);

  localparam logic [DATA_W-1:0] POS_LIMIT = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIMIT = {1'b1, {(DATA_W-1){1'b0}}};

  sat_op_e           op_dec;
  logic [DATA_W-1:0] clamp_res;
  logic              ovf_evt;
  logic              carry_evt;
  logic              res_zero;
  logic              res_neg;
  logic [DATA_W-1:0] result_q;

  assign op_dec = sat_op_e'(op_sel);

  sat_arith_core #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_core (
    .op      (op_dec),
    .src     (src_opnd),
    .dst     (dst_opnd),
    .imm     (imm_opnd),
    .clamped (clamp_res),
    .ovf     (ovf_evt),
    .carry   (carry_evt)
  );

  assign res_zero = (clamp_res == '0);
  assign res_neg  = clamp_res[DATA_W-1];

  sat_flag_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (op_valid),
    .new_z   (res_zero),
    .new_s   (res_neg),
    .new_ov  (ovf_evt),
    .new_cy  (carry_evt),
    .wr_en   (stat_wr),
    .wr_data (stat_wr_data),
    .flags_q (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        result_q <= '0;
    else if (op_valid) result_q <= clamp_res;
  end

  assign result = result_q;

  // R1: an overflowing operation delivers one of the two limits
  a_r1_clamp_limits: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !stat_wr && ovf_evt) |=> (result == POS_LIMIT || result == NEG_LIMIT));

  // R2: a clamp raises both OV and SAT
  a_r2_clamp_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !stat_wr && ovf_evt) |=> (status[FLG_OV] && status[FLG_SAT]));

  // R5: sign and zero flags agree with the delivered result
  a_r5_sz_track: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !stat_wr) |=> (status[FLG_S] == result[DATA_W-1] &&
                                status[FLG_Z] == (result == '0)));

  // R9: idle cycles hold both result and status
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !stat_wr) |=> ($stable(result) && $stable(status)));

endmodule

// File: tb/sat_alu_unit_tb.sv
module sat_alu_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_sel = 2'd0;
  logic [31:0] src_opnd = '0;
  logic [31:0] dst_opnd = '0;
  logic [15:0] imm_opnd = '0;
  logic        stat_wr = 1'b0;
  logic [4:0]  stat_wr_data = '0;
  logic [31:0] result;
  logic [4:0]  status;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sat_alu_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .src_opnd(src_opnd), .dst_opnd(dst_opnd), .imm_opnd(imm_opnd),
    .stat_wr(stat_wr), .stat_wr_data(stat_wr_data),
    .result(result), .status(status)
  );

  // Flag weights: SAT=16 CY=8 OV=4 S=2 Z=1
  localparam int NV = 18;
  localparam logic [1:0]  T_OP  [NV] = '{0,0,0,0, 1,1,1,1, 2, 3,3,3, 0,1, 0,0, 2, 3};
  localparam logic [31:0] T_DST [NV] = '{
    32'h70000000, 32'h90000000, 32'h0fffffff, 32'hf0000000,
    32'h70000000, 32'h90000000, 32'h0fffffff, 32'hf0000000,
    32'h90000000,
    32'h7ffffffe, 32'h80000001, 32'h7ffffffe,
    32'h0, 32'h5,
    32'h2, 32'h2,
    32'h3,
    32'h0};
  localparam logic [31:0] T_SRC [NV] = '{
    32'h70000000, 32'h90000000, 32'h70000000, 32'h90000000,
    32'h90000000, 32'h70000000, 32'h90000000, 32'h70000000,
    32'h70000000,
    32'h0, 32'h0, 32'h0,
    32'h0, 32'h5,
    32'h1, 32'h1,
    32'h5,
    32'h0};
  localparam logic [15:0] T_IMM [NV] = '{0,0,0,0, 0,0,0,0, 0,
    16'hfff6, 16'h000a, 16'hffff, 0,0, 0,0, 0, 16'h8000};
  localparam logic [4:0]  T_PRE [NV] = '{0,0,0,0, 0,0,0,0, 0, 0,0,0, 0,0, 5'h10, 5'h0f, 0, 0};
  localparam logic [31:0] T_RES [NV] = '{
    32'h7fffffff, 32'h80000000, 32'h7fffffff, 32'h80000000,   // R1 R6 add
    32'h7fffffff, 32'h80000000, 32'h7fffffff, 32'h80000000,   // R1 R4 R6 sub
    32'h7fffffff,                                             // R7 reverse
    32'h7fffffff, 32'h80000000, 32'h7fffffff,                 // R7 immediate
    32'h0, 32'h0,                                             // R5 zero
    32'h3, 32'h3,                                             // R3 sticky
    32'h2,                                                    // R7 reverse order
    32'h00008000};                                            // R7 sign extension
  localparam logic [4:0]  T_FLG [NV] = '{
    5'h14, 5'h1e, 5'h00, 5'h0a,
    5'h1c, 5'h16, 5'h08, 5'h02,
    5'h1c,
    5'h1c, 5'h16, 5'h08,
    5'h01, 5'h01,
    5'h10, 5'h00,
    5'h00,
    5'h08};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_status(input logic [4:0] v);
    @(negedge clk);
    stat_wr = 1'b1; stat_wr_data = v;
    @(negedge clk);
    stat_wr = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [31:0] d, input logic [31:0] s,
                        input logic [15:0] im);
    @(negedge clk);
    op_valid = 1'b1; op_sel = op; dst_opnd = d; src_opnd = s; imm_opnd = im;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset result", result, 32'h0);
    check("R10 reset status", {27'h0, status}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      write_status(T_PRE[i]);
      run_op(T_OP[i], T_DST[i], T_SRC[i], T_IMM[i]);
      check($sformatf("R1/R4/R6/R7 vector %0d result", i), result, T_RES[i]);
      check($sformatf("R2/R3/R4/R5/R6 vector %0d status", i), {27'h0, status}, {27'h0, T_FLG[i]});
    end

    // R3: clamp then a clean op without any status write keeps SAT
    write_status(5'h00);
    run_op(2'd0, 32'h70000000, 32'h70000000, 16'h0);
    check("R2 clamp status", {27'h0, status}, 32'h14);
    run_op(2'd0, 32'h1, 32'h1, 16'h0);
    check("R3 sticky result", result, 32'h2);
    check("R3 sticky status", {27'h0, status}, 32'h10);

    // R8: write loads status, result untouched
    write_status(5'h15);
    check("R8 write status", {27'h0, status}, 32'h15);
    check("R8 write keeps result", result, 32'h2);

    // R8: write wins over simultaneous operation, result still updated
    @(negedge clk);
    op_valid = 1'b1; op_sel = 2'd0; dst_opnd = 32'h1; src_opnd = 32'h2;
    stat_wr = 1'b1; stat_wr_data = 5'h03;
    @(negedge clk);
    op_valid = 1'b0; stat_wr = 1'b0;
    check("R8 collision status", {27'h0, status}, 32'h03);
    check("R8 collision result", result, 32'h3);

    // R9: idle cycles with changing operands hold outputs
    @(negedge clk);
    op_sel = 2'd1; dst_opnd = 32'h90000000; src_opnd = 32'h70000000;
    repeat (3) @(negedge clk);
    check("R9 hold result", result, 32'h3);
    check("R9 hold status", {27'h0, status}, 32'h03);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule